// File: doc/BRIEF.md
# Per-Way Load-Reserve Monitor

This block keeps the reservation state that backs load-linked / store-conditional pairs in a set-associative data cache. Every way of every set carries an owner field holding the context ID that last completed a locked read on that line, or an all-ones value meaning nobody holds it. Any event that changes a way's contents or rights cancels the reservation on that way: a fill, an eviction or a permission change. The caller does the tag lookup and presents a set index and a way with each event strobe. The block also tracks which ways hold a line, so that it can flag operations aimed at an empty way.

A store-conditional check compares the way's owner with the requesting context. It answers one cycle later with a pass flag and a result code. A pass consumes the reservation. A fail means the store must not be issued. A small combinational decoder sits alongside. It maps the request kinds, including the locked and read-modify-write kinds, onto the cache request class. It also reports which outstanding-request table each kind belongs to and whether a DMA-side requester may issue that kind.

Top module: `resv_monitor`

## Requirements
- R1: After reset every way is empty and unreserved. A check on any way then fails and raises `err_miss`.
- R2: A fill strobe marks the addressed way as holding a line, and leaves it unreserved even if it was reserved before.
- R3: A drop strobe marks the addressed way as empty and unreserved.
- R4: A permission-change strobe cancels the way's reservation and leaves the way holding its line.
- R5: A lock strobe on a way that holds a line makes `lock_ctx` the way's owner. On an empty way it changes nothing and pulses `err_miss` in the next cycle.
- R6: A check (`sc_vld`) is answered in the next cycle with `sc_done`=1. It passes only if the way holds a line and its owner equals `sc_ctx`. A pass gives `sc_code`=0. A fail gives `sc_code`=-2 in two's complement at CODE_W bits (0xFE for 8 bits).
- R7: A check that passes cancels the reservation, so a repeated check with no new lock fails.
- R8: A check on an empty way fails and pulses `err_miss` in the next cycle. A check on a way that holds a line never raises `err_miss`.
- R9: When a cancelling event (fill, drop, permission change or a passing check) and a lock hit the same way in one cycle, the way ends up unreserved. A check made in the same cycle as a lock on its way is judged on the owner from before that cycle.
- R10: `cache_cls` from `req_kind` uses these codes. `req_kind`: 0 load, 1 store, 2 instruction fetch, 3 locked read, 4 locked write, 5 RMW read, 6 RMW write, 7 none. `cache_cls`: 0 load, 1 store, 2 fetch, 3 atomic. Load and none map to 0, store and both locked kinds to 1, fetch to 2, and both RMW kinds to 3.
- R11: `wr_table` is 1 for kinds 1, 3, 4, 5 and 6. `dma_illegal` is 1 for every kind except 0 and 1.
- R12: A check whose `sc_ctx` is the all-ones value never passes, even on an unreserved way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_vld | input | 1 | A line is allocated into a way |
| fill_set | input | SET_W | Set of the fill |
| fill_way | input | WAY_W | Way of the fill |
| drop_vld | input | 1 | A way is deallocated |
| drop_set | input | SET_W | Set of the drop |
| drop_way | input | WAY_W | Way of the drop |
| perm_vld | input | 1 | A way's access permission changes |
| perm_set | input | SET_W | Set of the permission change |
| perm_way | input | WAY_W | Way of the permission change |
| lock_vld | input | 1 | A locked read completed |
| lock_set | input | SET_W | Set of the locked read |
| lock_way | input | WAY_W | Way of the locked read |
| lock_ctx | input | CTX_W | Context that performed the locked read |
| sc_vld | input | 1 | Store-conditional check request |
| sc_set | input | SET_W | Set of the check |
| sc_way | input | WAY_W | Way of the check |
| sc_ctx | input | CTX_W | Context performing the conditional store |
| req_kind | input | 3 | Request kind to classify |
| sc_done | output | 1 | Check answer valid (one cycle after `sc_vld`) |
| sc_pass | output | 1 | Check passed; the store may be issued |
| sc_code | output | CODE_W | 0 on pass, -2 on fail |
| err_miss | output | 1 | Previous lock or check addressed an empty way |
| cache_cls | output | 2 | Cache request class for `req_kind` |
| wr_table | output | 1 | Kind is tracked in the write-request table |
| dma_illegal | output | 1 | Kind must not come from a DMA requester |

## Verification
The bench builds the block with four sets, two ways and a two-bit context ID. With these values every way can be swept, and every context value, including the all-ones one, can be tried against every owner. Because the context field is only two bits wide, the all-ones ID sits right next to real IDs, which makes the R12 corner easy to hit. Same-cycle collisions between locks, cancelling events and checks are driven on chosen ways, and the decoder is swept over all eight request kinds.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [2:0] {
        KIND_LOAD    = 3'd0,
        KIND_STORE   = 3'd1,
        KIND_IFETCH  = 3'd2,
        KIND_LOCK_RD = 3'd3,
        KIND_LOCK_WR = 3'd4,
        KIND_RMW_RD  = 3'd5,
        KIND_RMW_WR  = 3'd6,
        KIND_NONE    = 3'd7
    } req_kind_e;

    typedef enum logic [1:0] {
        CLS_LOAD   = 2'd0,
        CLS_STORE  = 2'd1,
        CLS_IFETCH = 2'd2,
        CLS_ATOMIC = 2'd3
    } cache_cls_e;

endpackage

// File: rtl/resv_req_class.sv
module resv_req_class
    import resv_pkg::*;
(
    input  logic [2:0] kind_i,
    output logic [1:0] cls_o,
    output logic       wr_table_o,
    output logic       dma_bad_o
);

    always_comb begin
        cls_o      = CLS_LOAD;
        wr_table_o = 1'b0;
        dma_bad_o  = 1'b1;
        case (req_kind_e'(kind_i))
            KIND_LOAD: begin
                cls_o     = CLS_LOAD;
                dma_bad_o = 1'b0;
            end
            KIND_STORE: begin
                cls_o      = CLS_STORE;
                wr_table_o = 1'b1;
                dma_bad_o  = 1'b0;
            end
            KIND_IFETCH: begin
                cls_o = CLS_IFETCH;
            end
            KIND_LOCK_RD, KIND_LOCK_WR: begin
                // exclusive-ownership store request for both halves of the pair
                cls_o      = CLS_STORE;
                wr_table_o = 1'b1;
            end
            KIND_RMW_RD, KIND_RMW_WR: begin
                cls_o      = CLS_ATOMIC;
                wr_table_o = 1'b1;
            end
            default: begin
                cls_o = CLS_LOAD;
            end
        endcase
    end

endmodule

// File: rtl/resv_entry.sv
module resv_entry #(
    parameter int CTX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_i,
    input  logic             drop_i,
    input  logic             perm_i,
    input  logic             lock_i,
    input  logic [CTX_W-1:0] ctx_i,
    input  logic             consume_i,
    output logic [CTX_W-1:0] owner_o,
    output logic             present_o
);

    localparam logic [CTX_W-1:0] UNRES = {CTX_W{1'b1}};

    typedef struct packed {
        logic             present;
        logic [CTX_W-1:0] owner;
    } entry_t;

    entry_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (fill_i) begin
            ent_d.present = 1'b1;
        end
        if (drop_i) begin
            ent_d.present = 1'b0;
        end
        if (lock_i) begin
            ent_d.owner = ctx_i;
        end
        // any cancelling event overrides a same-cycle lock
        if (fill_i || drop_i || perm_i || consume_i) begin
            ent_d.owner = UNRES;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '{present: 1'b0, owner: UNRES};
        end else begin
            ent_q <= ent_d;
        end
    end

    assign owner_o   = ent_q.owner;
    assign present_o = ent_q.present;

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    parameter int CTX_W    = 4,
    parameter int CODE_W   = 8,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_vld,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic              drop_vld,
    input  logic [SET_W-1:0]  drop_set,
    input  logic [WAY_W-1:0]  drop_way,
    input  logic              perm_vld,
    input  logic [SET_W-1:0]  perm_set,
    input  logic [WAY_W-1:0]  perm_way,
    input  logic              lock_vld,
    input  logic [SET_W-1:0]  lock_set,
    input  logic [WAY_W-1:0]  lock_way,
    input  logic [CTX_W-1:0]  lock_ctx,
    input  logic              sc_vld,
    input  logic [SET_W-1:0]  sc_set,
    input  logic [WAY_W-1:0]  sc_way,
    input  logic [CTX_W-1:0]  sc_ctx,
    input  logic [2:0]        req_kind,
    output logic              sc_done,
    output logic              sc_pass,
    output logic [CODE_W-1:0] sc_code,
    output logic              err_miss,
    output logic [1:0]        cache_cls,
    output logic              wr_table,
    output logic              dma_illegal
);

    localparam int NENT                  = NUM_SETS * NUM_WAYS;
    localparam logic [CTX_W-1:0]  UNRES  = {CTX_W{1'b1}};
    localparam logic [CODE_W-1:0] C_FAIL = {{(CODE_W-1){1'b1}}, 1'b0};
    localparam logic [CODE_W-1:0] C_PASS = '0;

    typedef struct packed {
        logic              done;
        logic              pass;
        logic [CODE_W-1:0] code;
        logic              err;
    } rsp_t;

    logic [NENT-1:0]  fill_hit, drop_hit, perm_hit, lock_hit, sc_hit;
    logic [NENT-1:0]  lock_en, consume;
    logic [NENT-1:0]  present_v;
    logic [CTX_W-1:0] owner_v [NENT];

    logic             sc_present;
    logic             lock_present;
    logic [CTX_W-1:0] sc_owner;
    logic             sc_ok;

    rsp_t rsp_d, rsp_q;

    // one tracking entry per (set, way)
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            localparam int IDX = s * NUM_WAYS + w;
            localparam logic [SET_W-1:0] SI = SET_W'(s);
            localparam logic [WAY_W-1:0] WI = WAY_W'(w);

            assign fill_hit[IDX] = fill_vld && (fill_set == SI) && (fill_way == WI);
            assign drop_hit[IDX] = drop_vld && (drop_set == SI) && (drop_way == WI);
            assign perm_hit[IDX] = perm_vld && (perm_set == SI) && (perm_way == WI);
            assign lock_hit[IDX] = lock_vld && (lock_set == SI) && (lock_way == WI);
            assign sc_hit[IDX]   = sc_vld   && (sc_set   == SI) && (sc_way   == WI);

            resv_entry #(
                .CTX_W (CTX_W)
            ) u_entry (
                .clk       (clk),
                .rst_n     (rst_n),
                .fill_i    (fill_hit[IDX]),
                .drop_i    (drop_hit[IDX]),
                .perm_i    (perm_hit[IDX]),
                .lock_i    (lock_en[IDX]),
                .ctx_i     (lock_ctx),
                .consume_i (consume[IDX]),
                .owner_o   (owner_v[IDX]),
                .present_o (present_v[IDX])
            );
        end
    end

    // selection of the checked way and the response next-state
    always_comb begin
        sc_owner = '0;
        for (int i = 0; i < NENT; i++) begin
            if (sc_hit[i]) begin
                sc_owner = sc_owner | owner_v[i];
            end
        end
        sc_present   = |(sc_hit & present_v);
        lock_present = |(lock_hit & present_v);
        sc_ok        = sc_vld && sc_present && (sc_owner == sc_ctx) && (sc_ctx != UNRES);

        lock_en = lock_hit & present_v;
        consume = sc_ok ? sc_hit : '0;

        rsp_d      = '0;
        rsp_d.done = sc_vld;
        rsp_d.pass = sc_ok;
        rsp_d.code = sc_ok ? C_PASS : (sc_vld ? C_FAIL : C_PASS);
        rsp_d.err  = (lock_vld && !lock_present) || (sc_vld && !sc_present);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign sc_done  = rsp_q.done;
    assign sc_pass  = rsp_q.pass;
    assign sc_code  = rsp_q.code;
    assign err_miss = rsp_q.err;

    resv_req_class u_cls (
        .kind_i     (req_kind),
        .cls_o      (cache_cls),
        .wr_table_o (wr_table),
        .dma_bad_o  (dma_illegal)
    );

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int CTX_W  = 4,
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sc_vld,
    input logic [CTX_W-1:0]  sc_ctx,
    input logic              lock_vld,
    input logic              sc_done,
    input logic              sc_pass,
    input logic [CODE_W-1:0] sc_code,
    input logic              err_miss,
    input logic [2:0]        req_kind,
    input logic [1:0]        cache_cls,
    input logic              wr_table,
    input logic              dma_illegal
);

    localparam logic [CTX_W-1:0]  UNRES  = {CTX_W{1'b1}};
    localparam logic [CODE_W-1:0] C_FAIL = {{(CODE_W-1){1'b1}}, 1'b0};

    a_r6_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sc_vld |=> sc_done);

    a_r6_answer_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        sc_done |-> $past(sc_vld));

    a_r6_fail_code: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && !sc_pass) |-> (sc_code == C_FAIL));

    a_r6_pass_code: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |-> (sc_done && sc_code == '0));

    a_r12_allones_never_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_vld && sc_ctx == UNRES) |=> !sc_pass);

    a_r5_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_miss |-> $past(lock_vld || sc_vld));

    a_r8_pass_without_err: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |-> !err_miss);

    a_r10_rmw_is_atomic: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == 3'd5 || req_kind == 3'd6) |-> (cache_cls == 2'd3));

    a_r11_locked_in_write_table: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == 3'd3 || req_kind == 3'd4) |-> (wr_table && dma_illegal && cache_cls == 2'd1));

endmodule

bind resv_monitor resv_monitor_chk #(
    .CTX_W  (CTX_W),
    .CODE_W (CODE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sc_vld      (sc_vld),
    .sc_ctx      (sc_ctx),
    .lock_vld    (lock_vld),
    .sc_done     (sc_done),
    .sc_pass     (sc_pass),
    .sc_code     (sc_code),
    .err_miss    (err_miss),
    .req_kind    (req_kind),
    .cache_cls   (cache_cls),
    .wr_table    (wr_table),
    .dma_illegal (dma_illegal)
);

// File: tb/resv_monitor_bench.sv
module resv_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NS   = 4;
    localparam int NW   = 2;
    localparam int CW   = 2;
    localparam int CDW  = 8;
    localparam int SW   = 2;
    localparam int WW   = 1;
    localparam int UNRES  = (1 << CW) - 1;
    localparam int C_FAIL = (1 << CDW) - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fill_vld, drop_vld, perm_vld, lock_vld, sc_vld;
    logic [SW-1:0] fill_set, drop_set, perm_set, lock_set, sc_set;
    logic [WW-1:0] fill_way, drop_way, perm_way, lock_way, sc_way;
    logic [CW-1:0] lock_ctx, sc_ctx;
    logic [2:0] req_kind;
    logic sc_done, sc_pass, err_miss, wr_table, dma_illegal;
    logic [CDW-1:0] sc_code;
    logic [1:0] cache_cls;

    int checks = 0;
    int fails  = 0;
    int m_own  [NS][NW];
    bit m_pres [NS][NW];

    always #(CLK_PERIOD/2) clk = ~clk;

    resv_monitor #(
        .NUM_SETS (NS),
        .NUM_WAYS (NW),
        .CTX_W    (CW),
        .CODE_W   (CDW)
    ) u_resv_monitor (
        .clk (clk), .rst_n (rst_n),
        .fill_vld (fill_vld), .fill_set (fill_set), .fill_way (fill_way),
        .drop_vld (drop_vld), .drop_set (drop_set), .drop_way (drop_way),
        .perm_vld (perm_vld), .perm_set (perm_set), .perm_way (perm_way),
        .lock_vld (lock_vld), .lock_set (lock_set), .lock_way (lock_way), .lock_ctx (lock_ctx),
        .sc_vld (sc_vld), .sc_set (sc_set), .sc_way (sc_way), .sc_ctx (sc_ctx),
        .req_kind (req_kind),
        .sc_done (sc_done), .sc_pass (sc_pass), .sc_code (sc_code), .err_miss (err_miss),
        .cache_cls (cache_cls), .wr_table (wr_table), .dma_illegal (dma_illegal)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_in();
        fill_vld = 0; drop_vld = 0; perm_vld = 0; lock_vld = 0; sc_vld = 0;
        fill_set = '0; drop_set = '0; perm_set = '0; lock_set = '0; sc_set = '0;
        fill_way = '0; drop_way = '0; perm_way = '0; lock_way = '0; sc_way = '0;
        lock_ctx = '0; sc_ctx = '0;
    endtask

    // inputs set at a falling edge are captured at the next rising edge;
    // registered answers are then sampled at the following falling edge
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic op_fill(int s, int w);
        fill_vld = 1; fill_set = SW'(s); fill_way = WW'(w);
        tick(); clr_in();
        m_pres[s][w] = 1; m_own[s][w] = UNRES;
    endtask

    task automatic op_drop(int s, int w);
        drop_vld = 1; drop_set = SW'(s); drop_way = WW'(w);
        tick(); clr_in();
        m_pres[s][w] = 0; m_own[s][w] = UNRES;
    endtask

    task automatic op_perm(int s, int w);
        perm_vld = 1; perm_set = SW'(s); perm_way = WW'(w);
        tick(); clr_in();
        m_own[s][w] = UNRES;
    endtask

    task automatic op_lock(int s, int w, int c, string req);
        lock_vld = 1; lock_set = SW'(s); lock_way = WW'(w); lock_ctx = CW'(c);
        tick();
        chk(req, int'(err_miss), m_pres[s][w] ? 0 : 1);
        clr_in();
        if (m_pres[s][w]) m_own[s][w] = c;
    endtask

    task automatic op_sc(int s, int w, int c, string req);
        bit ep;
        ep = m_pres[s][w] && (m_own[s][w] == c) && (c != UNRES);
        sc_vld = 1; sc_set = SW'(s); sc_way = WW'(w); sc_ctx = CW'(c);
        tick();
        chk(req, int'(sc_done), 1);
        chk(req, int'(sc_pass), int'(ep));
        chk(req, int'(sc_code), ep ? 0 : C_FAIL);
        chk(req, int'(err_miss), m_pres[s][w] ? 0 : 1);
        clr_in();
        if (ep) m_own[s][w] = UNRES;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        clr_in();
        req_kind = 3'd0;
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                m_own[s][w] = UNRES; m_pres[s][w] = 0;
            end
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R1: reset state
        chk("R1 done", int'(sc_done), 0);
        chk("R1 err", int'(err_miss), 0);
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) op_sc(s, w, 0, "R1 R8 empty check");

        // R5: lock on empty way flags error and changes nothing
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) op_lock(s, w, 1, "R5 empty lock");

        // R2: fill all; unreserved afterwards
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) op_fill(s, w);
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) op_sc(s, w, 1, "R2 filled unreserved");

        // R6 R7 R12: every owner against every context, including all-ones
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) op_lock(s, w, (s * NW + w) % 3, "R5 lock present");
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++)
                for (int c = 0; c < 4; c++) op_sc(s, w, c, "R6 R12 owner sweep");
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) op_sc(s, w, (s * NW + w) % 3, "R7 consumed");

        // R4: permission change on odd ways
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) op_lock(s, w, 1, "R5 relock");
        for (int s = 0; s < NS; s++) op_perm(s, 1);
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) op_sc(s, w, 1, "R4 perm cancels");

        // R3: drop set 0
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) op_lock(s, w, 2, "R5 relock");
        for (int w = 0; w < NW; w++) op_drop(0, w);
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) op_sc(s, w, 2, "R3 drop cancels");
        for (int w = 0; w < NW; w++) op_fill(0, w);

        // R2: refill of a reserved way cancels it
        op_lock(1, 0, 0, "R5 relock");
        op_fill(1, 0);
        op_sc(1, 0, 0, "R2 refill cancels");

        // R9: lock and fill same way, same cycle
        lock_vld = 1; lock_set = 2'd2; lock_way = 1'b0; lock_ctx = 2'd1;
        fill_vld = 1; fill_set = 2'd2; fill_way = 1'b0;
        tick(); clr_in();
        m_own[2][0] = UNRES;
        op_sc(2, 0, 1, "R9 fill beats lock");

        // R9: lock and permission change same way, same cycle
        lock_vld = 1; lock_set = 2'd2; lock_way = 1'b1; lock_ctx = 2'd0;
        perm_vld = 1; perm_set = 2'd2; perm_way = 1'b1;
        tick(); clr_in();
        m_own[2][1] = UNRES;
        op_sc(2, 1, 0, "R9 perm beats lock");

        // R9: passing check and lock same cycle; check uses old owner, consume wins
        op_lock(3, 0, 0, "R5 setup");
        lock_vld = 1; lock_set = 2'd3; lock_way = 1'b0; lock_ctx = 2'd1;
        sc_vld = 1; sc_set = 2'd3; sc_way = 1'b0; sc_ctx = 2'd0;
        tick();
        chk("R9 old owner pass", int'(sc_pass), 1);
        chk("R9 old owner code", int'(sc_code), 0);
        clr_in();
        m_own[3][0] = UNRES;
        op_sc(3, 0, 1, "R9 consume beats lock");

        // R9: failing check and lock same cycle; lock takes effect
        op_lock(3, 1, 0, "R5 setup");
        lock_vld = 1; lock_set = 2'd3; lock_way = 1'b1; lock_ctx = 2'd1;
        sc_vld = 1; sc_set = 2'd3; sc_way = 1'b1; sc_ctx = 2'd1;
        tick();
        chk("R9 old owner fail", int'(sc_pass), 0);
        chk("R9 old owner fail code", int'(sc_code), C_FAIL);
        clr_in();
        m_own[3][1] = 1;
        op_sc(3, 1, 1, "R9 lock after failed check");

        // R10 R11: request classification
        for (int k = 0; k < 8; k++) begin
            int ec;
            req_kind = 3'(k);
            #1;
            ec = (k == 1 || k == 3 || k == 4) ? 1 : (k == 2) ? 2 : (k == 5 || k == 6) ? 3 : 0;
            chk("R10 class", int'(cache_cls), ec);
            chk("R11 write table", int'(wr_table), (k == 1 || (k >= 3 && k <= 6)) ? 1 : 0);
            chk("R11 dma illegal", int'(dma_illegal), (k >= 2) ? 1 : 0);
        end

        tick();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule